// File: doc/BRIEF.md
# Banked Core Register File

This block holds the architectural integer registers of a 32-bit processor core. Sixteen register indices are decoded from a 4-bit field: indices 0 to 12 are plain data registers, index 13 is the stack pointer, index 14 is the return-address register and index 15 is a view of the program counter. Two independent read ports and one write port serve the execute stage, and the read ports are purely combinational.

Two physical stack pointers exist, a main one and a process one. A select input decides which of them is seen at index 13. The other one is reached only through a dedicated side port that the special-register move logic uses. Stack pointer values are always word aligned.

The program counter view adds four on reads. Program counter writes must carry the low marker bit that denotes the compressed instruction state. A write without that bit is refused and reported on a one-cycle fault output. Decode, arithmetic, exception stacking and memory live elsewhere.

Top module: `core_regbank`

## Requirements
- R1: A cycle with `rst` high sets indices 0 to 12 and 14 to zero, the process stack pointer to zero, the program counter to zero, `pc_fault` low, and the main stack pointer to `rst_sp_val` with bits 1:0 cleared.
- R2: A write with `wr_en` high to index 0 to 12 or 14 is returned by both read ports from the cycle after the clock edge.
- R3: A read of the index being written in the same cycle returns the old value; there is no forwarding.
- R4: Index 13 reads and writes the main stack pointer when `sp_sel` is 0 and the process stack pointer when `sp_sel` is 1.
- R5: Bits 1:0 of either stack pointer always read as zero, whatever value is written through index 13 or through the side port.
- R6: `alt_rd_data` shows the stack pointer not selected by `sp_sel`; `alt_wr_en` writes that one only, and a write to index 13 leaves it unchanged.
- R7: Reading index 15 returns the stored program counter plus 4, modulo 2^32.
- R8: A write to index 15 whose bit 0 is 1 stores the value with bit 0 cleared and keeps `pc_fault` low.
- R9: A write to index 15 whose bit 0 is 0 leaves the program counter unchanged and drives `pc_fault` high for exactly the cycle after the clock edge.
- R10: With `wr_en` and `alt_wr_en` low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rst_sp_val | input | 32 | Main stack pointer value loaded at reset |
| sp_sel | input | 1 | 0 selects main, 1 selects process stack pointer at index 13 |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data, combinational |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data, combinational |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port register index |
| wr_data | input | 32 | Write port data |
| alt_rd_data | output | 32 | Inactive stack pointer value |
| alt_wr_en | input | 1 | Write enable for the inactive stack pointer |
| alt_wr_data | input | 32 | Data for the inactive stack pointer |
| pc_fault | output | 1 | Registered pulse after a program counter write with bit 0 clear |

## Verification
The bench builds the block with its default 32-bit data width, which makes the full alias map of the 4-bit index reachable and lets the program counter view wrap: a write of 0xFFFFFFFD stores 0xFFFFFFFC and reads back as zero. Directed scenarios switch `sp_sel` between writes so that the same index 13 reaches both stack pointers while the side port reaches the other, and misaligned values prove the low bits are dropped on both paths. Reset is applied a second time after registers hold non-zero data, and a same-cycle read of the write target shows the lack of forwarding.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int IDX_W = 4;
  localparam int NREG  = 1 << IDX_W;
  localparam logic [IDX_W-1:0] SP_IDX = 4'd13;
  localparam logic [IDX_W-1:0] LR_IDX = 4'd14;
  localparam logic [IDX_W-1:0] PC_IDX = 4'd15;
  localparam int PC_STEP    = 4;
  localparam int SP_LOW_ZERO = 2;
  typedef enum logic {SP_MAIN = 1'b0, SP_PROC = 1'b1} sp_sel_e;
endpackage

// File: rtl/gpr_array.sv
module gpr_array
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] rb_data
);
  logic [DATA_W-1:0] mem [NREG];
  logic              store_ok;

  assign store_ok = we && (widx != SP_IDX) && (widx != PC_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (store_ok) begin
      mem[widx] <= wdata;
    end
  end

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];
endmodule

// File: rtl/sp_bank.sv
module sp_bank
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rst_val,
  input  logic              sel,
  input  logic              act_we,
  input  logic [DATA_W-1:0] act_wdata,
  input  logic              alt_we,
  input  logic [DATA_W-1:0] alt_wdata,
  output logic [DATA_W-1:0] act_rdata,
  output logic [DATA_W-1:0] alt_rdata
);
  localparam int HI_W = DATA_W - SP_LOW_ZERO;

  logic [HI_W-1:0] sp_hi [2];

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_sp
      logic own_act, own_alt;
      assign own_act = act_we && (sel == g[0]);
      assign own_alt = alt_we && (sel != g[0]);
      always_ff @(posedge clk) begin
        if (rst) begin
          sp_hi[g] <= (g == int'(SP_MAIN)) ? rst_val[DATA_W-1:SP_LOW_ZERO] : '0;
        end else if (own_act) begin
          sp_hi[g] <= act_wdata[DATA_W-1:SP_LOW_ZERO];
        end else if (own_alt) begin
          sp_hi[g] <= alt_wdata[DATA_W-1:SP_LOW_ZERO];
        end
      end
    end
  endgenerate

  assign act_rdata = {sp_hi[sel],  {SP_LOW_ZERO{1'b0}}};
  assign alt_rdata = {sp_hi[~sel], {SP_LOW_ZERO{1'b0}}};
endmodule

// File: rtl/pc_unit.sv
module pc_unit
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] view,
  output logic              fault
);
  logic [DATA_W-1:1] pc_hi;
  logic              bad_wr;

  assign bad_wr = we && !wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_hi <= '0;
      fault <= 1'b0;
    end else begin
      fault <= bad_wr;
      if (we && wdata[0]) pc_hi <= wdata[DATA_W-1:1];
    end
  end

  assign view = {pc_hi, 1'b0} + DATA_W'(PC_STEP);
endmodule

// File: rtl/core_regbank.sv
module core_regbank
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rst_sp_val,
  input  logic              sp_sel,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] alt_rd_data,
  input  logic              alt_wr_en,
  input  logic [DATA_W-1:0] alt_wr_data,
  output logic              pc_fault
);
  logic [DATA_W-1:0] gpr_a, gpr_b, sp_act, pc_view;

  gpr_array #(.DATA_W(DATA_W)) u_gpr (
    .clk(clk), .rst(rst), .we(wr_en), .widx(wr_idx), .wdata(wr_data),
    .ra_idx(rd_a_idx), .ra_data(gpr_a), .rb_idx(rd_b_idx), .rb_data(gpr_b)
  );

  sp_bank #(.DATA_W(DATA_W)) u_sp (
    .clk(clk), .rst(rst), .rst_val(rst_sp_val), .sel(sp_sel),
    .act_we(wr_en && (wr_idx == SP_IDX)), .act_wdata(wr_data),
    .alt_we(alt_wr_en), .alt_wdata(alt_wr_data),
    .act_rdata(sp_act), .alt_rdata(alt_rd_data)
  );

  pc_unit #(.DATA_W(DATA_W)) u_pc (
    .clk(clk), .rst(rst), .we(wr_en && (wr_idx == PC_IDX)), .wdata(wr_data),
    .view(pc_view), .fault(pc_fault)
  );

  function automatic logic [DATA_W-1:0] pick(input logic [IDX_W-1:0] idx,
                                             input logic [DATA_W-1:0] gval);
    if (idx == SP_IDX)      return sp_act;
    else if (idx == PC_IDX) return pc_view;
    else                    return gval;
  endfunction

  always_comb begin
    rd_a_data = pick(rd_a_idx, gpr_a);
    rd_b_data = pick(rd_b_idx, gpr_b);
  end
endmodule

// File: rtl/core_regbank_chk.sv
module core_regbank_chk
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] rst_sp_val,
  input logic              sp_sel,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [IDX_W-1:0]  rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] alt_rd_data,
  input logic              alt_wr_en,
  input logic [DATA_W-1:0] alt_wr_data,
  input logic              pc_fault
);
  AST_RESET_MSP: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && rd_a_idx == SP_IDX && sp_sel == 1'b0)
      |-> rd_a_data == {$past(rst_sp_val[DATA_W-1:2]), 2'b00}); // R1
  AST_SP_ALIGN_A: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == SP_IDX) |-> rd_a_data[1:0] == 2'b00); // R5
  AST_SP_ALIGN_ALT: assert property (@(posedge clk) disable iff (rst)
    alt_rd_data[1:0] == 2'b00); // R5
  AST_ALT_WRITE: assert property (@(posedge clk) disable iff (rst)
    alt_wr_en |=> (!$stable(sp_sel) ||
                   alt_rd_data == {$past(alt_wr_data[DATA_W-1:2]), 2'b00})); // R6
  AST_PC_VIEW_EVEN: assert property (@(posedge clk) disable iff (rst)
    (rd_b_idx == PC_IDX) |-> rd_b_data[0] == 1'b0); // R7
  AST_FAULT_RAISE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == PC_IDX && !wr_data[0]) |=> pc_fault); // R9
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_idx == PC_IDX && !wr_data[0]) |=> !pc_fault); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !alt_wr_en && $stable(sp_sel)) |=>
      (!$stable(rd_a_idx) || $stable(rd_a_data))); // R10
endmodule

bind core_regbank core_regbank_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/core_regbank_test.sv
`timescale 1ns/1ps
module core_regbank_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] rst_sp_val;
  logic        sp_sel;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, alt_rd_data, alt_wr_data;
  logic        wr_en, alt_wr_en, pc_fault;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  core_regbank uut (
    .clk(clk), .rst(rst), .rst_sp_val(rst_sp_val), .sp_sel(sp_sel),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .alt_rd_data(alt_rd_data), .alt_wr_en(alt_wr_en),
    .alt_wr_data(alt_wr_data), .pc_fault(pc_fault)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic alt_wr(input logic [31:0] d);
    @(negedge clk);
    alt_wr_en = 1'b1; alt_wr_data = d;
    @(posedge clk); #1;
    alt_wr_en = 1'b0;
  endtask

  task automatic rd_a(input logic [3:0] idx, output logic [31:0] d);
    rd_a_idx = idx; #0.5; d = rd_a_data;
  endtask

  task automatic rd_b(input logic [3:0] idx, output logic [31:0] d);
    rd_b_idx = idx; #0.5; d = rd_b_data;
  endtask

  task automatic t_reset_r1();
    logic [31:0] v;
    @(negedge clk);
    rst = 1'b1; rst_sp_val = 32'h2000_1003; sp_sel = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 13; i++) begin
      rd_a(4'(i), v); chk("R1 gpr zero", v, 32'h0);
    end
    rd_a(4'd14, v);   chk("R1 link zero", v, 32'h0);
    rd_a(4'd13, v);   chk("R1 main sp", v, 32'h2000_1000);
    chk("R1 process sp zero", alt_rd_data, 32'h0);
    rd_a(4'd15, v);   chk("R1 pc view", v, 32'h4);
    chk("R1 fault low", {31'b0, pc_fault}, 32'h0);
  endtask

  task automatic t_gpr_r2();
    logic [31:0] v;
    for (int i = 0; i < 13; i++) wr(4'(i), 32'hA5A5_0000 + 32'(i * 17));
    wr(4'd14, 32'h0800_0123);
    for (int i = 0; i < 13; i++) begin
      rd_a(4'(i), v); chk("R2 port a", v, 32'hA5A5_0000 + 32'(i * 17));
      rd_b(4'(12 - i), v); chk("R2 port b", v, 32'hA5A5_0000 + 32'((12 - i) * 17));
    end
    rd_b(4'd14, v); chk("R2 link", v, 32'h0800_0123);
  endtask

  task automatic t_noforward_r3();
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'hDEAD_BEEF; rd_a_idx = 4'd3;
    #0.5; chk("R3 old value same cycle", rd_a_data, 32'hA5A5_0033);
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk("R3 new value next cycle", rd_a_data, 32'hDEAD_BEEF);
  endtask

  task automatic t_sp_r4_r5_r6();
    logic [31:0] v;
    sp_sel = 1'b0;
    wr(4'd13, 32'h1000_0007);
    rd_a(4'd13, v); chk("R4 R5 main via 13", v, 32'h1000_0004);
    chk("R6 alt is process", alt_rd_data, 32'h0);
    alt_wr(32'h3000_00FF);
    chk("R6 R5 alt write process", alt_rd_data, 32'h3000_00FC);
    rd_a(4'd13, v); chk("R6 main untouched", v, 32'h1000_0004);
    sp_sel = 1'b1; #0.5;
    rd_a(4'd13, v); chk("R4 process via 13", v, 32'h3000_00FC);
    chk("R6 alt is main", alt_rd_data, 32'h1000_0004);
    wr(4'd13, 32'h3000_0102);
    rd_b(4'd13, v); chk("R4 R5 process write", v, 32'h3000_0100);
    chk("R6 main unchanged by 13", alt_rd_data, 32'h1000_0004);
    alt_wr(32'h1000_0201);
    chk("R6 R5 alt write main", alt_rd_data, 32'h1000_0200);
    sp_sel = 1'b0; #0.5;
    rd_a(4'd13, v); chk("R4 back to main", v, 32'h1000_0200);
  endtask

  task automatic t_pc_r7_r8();
    logic [31:0] v;
    wr(4'd15, 32'h0000_0101);
    chk("R8 fault low", {31'b0, pc_fault}, 32'h0);
    rd_a(4'd15, v); chk("R7 R8 pc view", v, 32'h0000_0104);
    wr(4'd15, 32'hFFFF_FFFD);
    rd_b(4'd15, v); chk("R7 wrap", v, 32'h0000_0000);
    wr(4'd15, 32'h0000_2003);
    rd_a(4'd15, v); chk("R8 bit0 cleared", v, 32'h0000_2006);
  endtask

  task automatic t_fault_r9();
    logic [31:0] v;
    wr(4'd15, 32'h0000_4000);
    chk("R9 fault high", {31'b0, pc_fault}, 32'h1);
    rd_a(4'd15, v); chk("R9 pc unchanged", v, 32'h0000_2006);
    @(posedge clk); #1;
    chk("R9 fault one cycle", {31'b0, pc_fault}, 32'h0);
  endtask

  task automatic t_idle_r10();
    logic [31:0] v;
    @(negedge clk);
    wr_idx = 4'd5; wr_data = 32'h1234_5678; alt_wr_data = 32'h5555_5554;
    repeat (3) @(posedge clk);
    #1;
    rd_a(4'd5, v);  chk("R10 gpr held", v, 32'hA5A5_0055);
    rd_a(4'd13, v); chk("R10 sp held", v, 32'h1000_0200);
    chk("R10 alt held", alt_rd_data, 32'h3000_0100);
  endtask

  initial begin
    rst = 1'b1; rst_sp_val = '0; sp_sel = 1'b0;
    rd_a_idx = '0; rd_b_idx = '0; wr_idx = '0; wr_data = '0;
    wr_en = 1'b0; alt_wr_en = 1'b0; alt_wr_data = '0;
    repeat (2) @(posedge clk);
    t_reset_r1();
    t_gpr_r2();
    t_noforward_r3();
    t_sp_r4_r5_r6();
    t_pc_r7_r8();
    t_fault_r9();
    t_idle_r10();
    t_reset_r1();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule